// File: doc/BRIEF.md
# Voltage and Frequency Operating Point Stepper

This block moves a processor domain between a small set of voltage and frequency operating points. Software writes a target performance index into a register. The block then walks the current index toward that target one level at a time. For each level it takes the supply code from an internal voltage table. A handshake with an external power unit reports when each new supply level is stable, and a clock-select output chooses the core frequency.

On the way up, the supply is raised first and the clock is switched only after the power unit acknowledges. On the way down, the clock is slowed first and the lower supply is requested afterwards. As a result the core frequency never runs ahead of the voltage that has been confirmed.

A maximum-performance input overrides the programmed target with the top level while it is high. When it falls, stepping resumes toward the value software wrote. A status register shows the current index, the effective target and a busy bit.

Top module: `dvs_level_ctrl`

## Requirements
- R1: After reset the current index and clock select are 0, no voltage request is raised, the voltage code output holds the level-0 code and the target register reads 0.
- R2: A write to register address 0 sets the software target, and a read of address 0 returns it. A written value above the top index (3) is stored and read back as 3, the nearest available level.
- R3: The voltage code for index i is VCODE_BASE + i*VCODE_STEP, which is 40 + 20*i with the default parameters.
- R4: On an upward step the block raises volt_req_o with the next level's code and holds both the request and the code until volt_ack_i is seen. Clock select and the current index increase on the edge that samples the acknowledge.
- R5: On a downward step clock select drops to the lower index on the same edge that raises volt_req_o with the lower code. The current index drops on the edge that samples the acknowledge.
- R6: The current index changes by exactly one level per step, upward or downward. The frequency selected never needs a higher code than the last acknowledged supply.
- R7: While max_perf_i is high the effective target is index 3 and the domain climbs to it. The software target register is left unchanged, and once max_perf_i falls the domain returns to the software target.
- R8: A target write that arrives while a step is in progress takes effect only after that step completes, so the step's level is always reached first.
- R9: Register address 1 reads the status: bits [1:0] hold the current index, bits [3:2] the effective target, and bit 4 is busy. Busy is set exactly when the current index differs from the effective target.
- R10: Writing a target equal to the current index raises no voltage request and leaves clock select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address (0 target, 1 status) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| max_perf_i | input | 1 | Force the top performance level |
| volt_req_o | output | 1 | Supply change request to the power unit |
| volt_code_o | output | 8 | Requested supply code |
| volt_ack_i | input | 1 | Power unit reports the requested supply is stable |
| clk_sel_o | output | 2 | Frequency level select |

## Verification
A corrupted step register or state shows up at the ports within one cycle of the next acknowledge. The clock select then lands on the wrong level, or the current index jumps by more than one, and a monitor comparing the selected level's table code against the last acknowledged code catches it. A wrong effective target appears at once in the status read. A lost target write shows as a path that stops at the wrong index once the handshakes settle. Sequencing errors, such as raising the clock before the acknowledge or lowering the supply before the clock, show as an ordering violation in the same cycle they occur.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_DN   = 2'd2
  } step_state_e;

  localparam logic REG_TARGET = 1'b0;
  localparam logic REG_STATUS = 1'b1;
endpackage

// File: rtl/dvs_vtable.sv
module dvs_vtable #(
  parameter int NUM_LEVELS = 4,
  parameter int IDX_W      = 2,
  parameter int VCODE_W    = 8,
  parameter int VCODE_BASE = 40,
  parameter int VCODE_STEP = 20
) (
  input  logic [IDX_W-1:0]   idx_i,
  output logic [VCODE_W-1:0] code_o
);
  logic [VCODE_W-1:0] table_q [NUM_LEVELS];

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_ent
    assign table_q[g] = VCODE_W'(VCODE_BASE + g * VCODE_STEP);
  end

  always_comb begin
    code_o = table_q[0];
    for (int i = 0; i < NUM_LEVELS; i++)
      if (idx_i == IDX_W'(i)) code_o = table_q[i];
  end
endmodule

// File: rtl/dvs_target_reg.sv
module dvs_target_reg #(
  parameter int IDX_W   = 2,
  parameter int DATA_W  = 8,
  parameter int MAX_IDX = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              max_perf_i,
  output logic [IDX_W-1:0]  sw_tgt_o,
  output logic [IDX_W-1:0]  eff_tgt_o
);
  logic [IDX_W-1:0] sw_tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_tgt_q <= '0;
    end else if (wr_i) begin
      // clamp to nearest available level
      if (wdata_i > DATA_W'(MAX_IDX)) sw_tgt_q <= IDX_W'(MAX_IDX);
      else                            sw_tgt_q <= wdata_i[IDX_W-1:0];
    end
  end

  assign sw_tgt_o  = sw_tgt_q;
  assign eff_tgt_o = max_perf_i ? IDX_W'(MAX_IDX) : sw_tgt_q;
endmodule

// File: rtl/dvs_step_fsm.sv
module dvs_step_fsm
  import dvs_pkg::*;
#(
  parameter int IDX_W   = 2,
  parameter int VCODE_W = 8,
  parameter logic [VCODE_W-1:0] RST_CODE = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   eff_tgt_i,
  input  logic               volt_ack_i,
  input  logic [VCODE_W-1:0] nxt_code_i,
  output logic [IDX_W-1:0]   nxt_idx_o,
  output logic [IDX_W-1:0]   cur_idx_o,
  output logic [IDX_W-1:0]   clk_sel_o,
  output logic               volt_req_o,
  output logic [VCODE_W-1:0] volt_code_o
);
  step_state_e      state_q;
  logic [IDX_W-1:0] step_q, cur_q, sel_q, nxt_idx;
  logic             req_q;
  logic [VCODE_W-1:0] code_q;
  logic             go_up, go_dn;

  assign go_up = eff_tgt_i > cur_q;
  assign go_dn = eff_tgt_i < cur_q;

  always_comb begin
    if (state_q != ST_IDLE) nxt_idx = step_q;
    else if (go_up)         nxt_idx = cur_q + 1'b1;
    else                    nxt_idx = cur_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cur_q   <= '0;
      sel_q   <= '0;
      req_q   <= 1'b0;
      code_q  <= RST_CODE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (go_up || go_dn) begin
            step_q <= nxt_idx;
            req_q  <= 1'b1;
            code_q <= nxt_code_i;
            if (go_dn) begin
              sel_q   <= nxt_idx;  // slow the clock before the supply drops
              state_q <= ST_DN;
            end else begin
              state_q <= ST_UP;
            end
          end
        end
        ST_UP: begin
          if (volt_ack_i) begin
            sel_q   <= step_q;     // supply confirmed, speed up now
            cur_q   <= step_q;
            req_q   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_DN: begin
          if (volt_ack_i) begin
            cur_q   <= step_q;
            req_q   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign nxt_idx_o   = nxt_idx;
  assign cur_idx_o   = cur_q;
  assign clk_sel_o   = sel_q;
  assign volt_req_o  = req_q;
  assign volt_code_o = code_q;
endmodule

// File: rtl/dvs_level_ctrl.sv
module dvs_level_ctrl
  import dvs_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int DATA_W     = 8,
  parameter int VCODE_W    = 8,
  parameter int VCODE_BASE = 40,
  parameter int VCODE_STEP = 20,
  localparam int IDX_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  localparam int MAX_IDX   = NUM_LEVELS - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               max_perf_i,
  output logic               volt_req_o,
  output logic [VCODE_W-1:0] volt_code_o,
  input  logic               volt_ack_i,
  output logic [IDX_W-1:0]   clk_sel_o
);
  logic [IDX_W-1:0]   sw_tgt, eff_tgt, cur_idx, nxt_idx;
  logic [VCODE_W-1:0] nxt_code;
  logic               busy;

  dvs_target_reg #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W),
    .MAX_IDX(MAX_IDX)
  ) u_tgt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i && (reg_addr_i == REG_TARGET)),
    .wdata_i   (reg_wdata_i),
    .max_perf_i(max_perf_i),
    .sw_tgt_o  (sw_tgt),
    .eff_tgt_o (eff_tgt)
  );

  dvs_vtable #(
    .NUM_LEVELS(NUM_LEVELS),
    .IDX_W     (IDX_W),
    .VCODE_W   (VCODE_W),
    .VCODE_BASE(VCODE_BASE),
    .VCODE_STEP(VCODE_STEP)
  ) u_vtab (
    .idx_i (nxt_idx),
    .code_o(nxt_code)
  );

  dvs_step_fsm #(
    .IDX_W   (IDX_W),
    .VCODE_W (VCODE_W),
    .RST_CODE(VCODE_W'(VCODE_BASE))
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eff_tgt_i  (eff_tgt),
    .volt_ack_i (volt_ack_i),
    .nxt_code_i (nxt_code),
    .nxt_idx_o  (nxt_idx),
    .cur_idx_o  (cur_idx),
    .clk_sel_o  (clk_sel_o),
    .volt_req_o (volt_req_o),
    .volt_code_o(volt_code_o)
  );

  assign busy = (cur_idx != eff_tgt);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == REG_STATUS) begin
      reg_rdata_o[IDX_W-1:0]       = cur_idx;
      reg_rdata_o[2*IDX_W-1:IDX_W] = eff_tgt;
      reg_rdata_o[2*IDX_W]         = busy;
    end else begin
      reg_rdata_o[IDX_W-1:0] = sw_tgt;
    end
  end
endmodule

// File: rtl/dvs_level_ctrl_chk.sv
module dvs_level_ctrl_chk #(
  parameter int IDX_W   = 2,
  parameter int VCODE_W = 8,
  parameter int MAX_IDX = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               volt_req_o,
  input logic               volt_ack_i,
  input logic [VCODE_W-1:0] volt_code_o,
  input logic [IDX_W-1:0]   clk_sel_o,
  input logic [IDX_W-1:0]   cur_idx,
  input logic [IDX_W-1:0]   eff_tgt,
  input logic               max_perf_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (volt_req_o && !volt_ack_i) |=> (volt_req_o && $stable(volt_code_o))); // R4

  AST_CLK_UP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_o > $past(clk_sel_o)) |-> $past(volt_req_o && volt_ack_i)); // R4

  AST_CLK_DOWN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(volt_req_o) && (volt_code_o < $past(volt_code_o))) |-> (clk_sel_o < $past(clk_sel_o))); // R5

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_idx != $past(cur_idx)) |->
      ((cur_idx == $past(cur_idx) + 1'b1) || (cur_idx == $past(cur_idx) - 1'b1))); // R6

  AST_CUR_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_idx != $past(cur_idx)) |-> $past(volt_req_o && volt_ack_i)); // R6

  AST_MAX_PERF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_perf_i |-> (eff_tgt == IDX_W'(MAX_IDX))); // R7
endmodule

bind dvs_level_ctrl dvs_level_ctrl_chk #(
  .IDX_W  (IDX_W),
  .VCODE_W(VCODE_W),
  .MAX_IDX(MAX_IDX)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .volt_req_o (volt_req_o),
  .volt_ack_i (volt_ack_i),
  .volt_code_o(volt_code_o),
  .clk_sel_o  (clk_sel_o),
  .cur_idx    (cur_idx),
  .eff_tgt    (eff_tgt),
  .max_perf_i (max_perf_i)
);

// File: tb/dvs_level_ctrl_tb.sv
module dvs_level_ctrl_tb;
  localparam int DATA_W = 8;
  localparam int VC_W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_addr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic max_perf = 1'b0;
  logic volt_req;
  logic [VC_W-1:0] volt_code;
  logic volt_ack = 1'b0;
  logic [1:0] clk_sel;

  int n_tests = 0;
  int n_fail  = 0;
  int ack_dly = 2;
  int ack_cnt = 0;
  int viol    = 0;
  int path_n  = 0;
  int path [16];
  int prev_cur = 0;
  logic [VC_W-1:0] acked_code = 8'd40;
  logic [1:0] prev_sel = '0;
  logic prev_req = 1'b0;

  dvs_level_ctrl u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .reg_wr_i   (reg_wr),
    .reg_addr_i (reg_addr),
    .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .max_perf_i (max_perf),
    .volt_req_o (volt_req),
    .volt_code_o(volt_code),
    .volt_ack_i (volt_ack),
    .clk_sel_o  (clk_sel)
  );

  always #5 clk = ~clk;

  function automatic logic [VC_W-1:0] vexp(input int i);
    return VC_W'(40 + 20 * i);  // R3
  endfunction

  // power unit model: acknowledge after ack_dly cycles of request
  always @(posedge clk) begin
    #2;
    if (volt_req && !volt_ack) begin
      if (ack_cnt >= ack_dly) begin volt_ack = 1'b1; ack_cnt = 0; end
      else ack_cnt++;
    end else begin
      volt_ack = 1'b0;
    end
  end

  // ordering monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (vexp(int'(clk_sel)) > acked_code) viol++;                      // R6
      if (volt_req && !prev_req && volt_code < acked_code && clk_sel >= prev_sel)
        viol++;                                                          // R5
      if (volt_req && volt_ack) acked_code = volt_code;
      if (int'(u_cur()) != prev_cur) begin
        if (int'(u_cur()) - prev_cur != 1 && prev_cur - int'(u_cur()) != 1) viol++;
        if (path_n < 16) path[path_n] = int'(u_cur());
        path_n++;
        prev_cur = int'(u_cur());
      end
      prev_sel = clk_sel;
      prev_req = volt_req;
    end
  end

  // current index through the status register port only
  function automatic logic [1:0] u_cur();
    return (reg_addr == 1'b1) ? reg_rdata[1:0] : prev_cur[1:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input int d);
    @(negedge clk);
    reg_addr = a; reg_wdata = DATA_W'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b1;
  endtask

  task automatic rd(input logic a, output int d);
    reg_addr = a; #1; d = int'(reg_rdata); reg_addr = 1'b1;
  endtask

  task automatic wait_idle();
    int st;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      rd(1'b1, st);
      if (st[4] == 1'b0 && !volt_req) break;
    end
  endtask

  task automatic clear_mon();
    path_n = 0; viol = 0;
  endtask

  task automatic t_reset();
    int d;
    check("R1 clk_sel", int'(clk_sel), 0);
    check("R1 req", int'(volt_req), 0);
    check("R1 code", int'(volt_code), 40);
    rd(1'b0, d); check("R1 target", d, 0);
    rd(1'b1, d); check("R1 status", d, 0);
  endtask

  task automatic t_up();
    int d;
    clear_mon();
    wr(1'b0, 3);
    @(negedge clk); #1;
    check("R4 req raised", int'(volt_req), 1);
    check("R3 code lvl1", int'(volt_code), 40 + 20);
    check("R4 clk held", int'(clk_sel), 0);
    rd(1'b1, d); check("R9 busy", d, 32'h1C);
    wait_idle();
    check("R4 clk_sel", int'(clk_sel), 3);
    check("R3 code lvl3", int'(volt_code), int'(vexp(3)));
    rd(1'b1, d); check("R9 status idle", d, 32'h0F);
    check("R6 steps", path_n, 3);
    check("R6 order", viol, 0);
  endtask

  task automatic t_down();
    int d;
    clear_mon();
    wr(1'b0, 1);
    @(negedge clk); #1;
    check("R5 clk first", int'(clk_sel), 2);
    check("R5 req", int'(volt_req), 1);
    check("R5 code", int'(volt_code), int'(vexp(2)));
    rd(1'b1, d); check("R5 cur held", d & 3, 3);
    wait_idle();
    check("R5 clk_sel", int'(clk_sel), 1);
    check("R5 code final", int'(volt_code), int'(vexp(1)));
    check("R6 steps", path_n, 2);
    check("R6 order", viol, 0);
  endtask

  task automatic t_maxperf();
    int d;
    clear_mon();
    @(negedge clk); max_perf = 1'b1;
    #1; rd(1'b1, d); check("R7 eff target", (d >> 2) & 3, 3);
    wait_idle();
    check("R7 clk top", int'(clk_sel), 3);
    rd(1'b0, d); check("R7 sw target kept", d, 1);
    @(negedge clk); max_perf = 1'b0;
    wait_idle();
    check("R7 return", int'(clk_sel), 1);
    check("R7 order", viol, 0);
  endtask

  task automatic t_clamp();
    int d;
    wr(1'b0, 200);
    rd(1'b0, d); check("R2 clamp", d, 3);
    wait_idle();
    wr(1'b0, 2);
    rd(1'b0, d); check("R2 readback", d, 2);
    wait_idle();
    check("R2 level", int'(clk_sel), 2);
  endtask

  task automatic t_same();
    int seen = 0;
    wr(1'b0, 2);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (volt_req) seen++;
    end
    check("R10 no request", seen, 0);
    check("R10 clk kept", int'(clk_sel), 2);
  endtask

  task automatic t_retarget();
    clear_mon();
    ack_dly = 6;
    wr(1'b0, 1);
    wait_idle();
    clear_mon();
    wr(1'b0, 3);
    @(negedge clk);
    wr(1'b0, 0);
    wait_idle();
    check("R8 path len", path_n, 3);
    check("R8 first step", path[0], 2);
    check("R8 second", path[1], 1);
    check("R8 end", path[2], 0);
    check("R8 clk", int'(clk_sel), 0);
    check("R8 order", viol, 0);
    ack_dly = 2;
  endtask

  initial begin
    reg_addr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up();
    t_down();
    t_maxperf();
    t_clamp();
    t_same();
    t_retarget();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule